// File: doc/BRIEF.md
# Chained Indirect Address Resolver

This block turns a five-digit decimal operand address into the effective address that an instruction actually uses. The units digit of an address can carry a flag. When the flag is set, the address is indirect: it names a five-digit field in digit memory whose digits form the next address. The resolver reads that field and puts the result in place of the current address. It repeats this as long as the new units digit is still flagged, so a chain can be followed to any depth.

A controller starts resolution with a one-cycle `start` pulse. The resolver then drives a read-only digit port into main memory. When it finishes it pulses `done` and presents the effective address in two forms: BCD for the instruction register and binary for the memory port. With the result it reports how many indirection levels it followed and the memory-time charge of the chain. A programmable depth limit stops a chain that would otherwise never end, and reports it as an error. Memory is only ever read, so the stored instruction stays as it was.

Top module: `indirect_chain_resolver`

## Requirements
- R1: While reset is low and after it, `busy`, `done`, `err`, `mem_rd_en`, `levels` and `cost` are all 0.
- R2: If the units flag of the start address is clear, the resolver does not read memory. `eff_bcd` equals the start address and `levels` is 0.
- R3: For an indirect address A, the resolver makes five reads on consecutive cycles, at addresses A-4, A-3, A-2, A-1 and A in that order. Read data is valid one cycle after `mem_rd_en`. The digit read at A-4 becomes the high-order digit (bits 19:16) of the new address, and the digit read at A becomes its units digit (bits 3:0).
- R4: A fetched address is always exactly five digits long. Flags on its four upper digits are ignored. Only the flag read with the units digit (at A) decides whether the chain goes on.
- R5: The resolver keeps following the chain while the units digit is flagged. It ends at the first address whose units digit is unflagged and outputs that address.
- R6: `levels` counts the indirections followed. `cost` rises by 4 for every level followed.
- R7: A read below address 0 wraps to the top of memory: address A-k with A<k becomes MEM_DIGITS+A-k.
- R8: If the current address is flagged and `levels` already equals `max_depth`, resolution ends at once with `err`=1 and no more reads. `eff_bcd` then holds that last flagged address.
- R9: `done` is a one-cycle pulse. It rises at the clock edge 1+7·L after the edge that accepted `start`, where L is the final value of `levels`.
- R10: `eff_bin` is the binary value of the decimal number in `eff_bcd`.
- R11: A `start` pulse that arrives while `busy` is 1 is ignored and does not change the result being produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start request, taken only when idle |
| addr_bcd_in | input | 20 | Start address, five BCD digits, units digit in bits 3:0 |
| addr_flag_in | input | 1 | Flag on the units digit of the start address (1 = indirect) |
| max_depth | input | DEPTH_W | Largest number of levels allowed |
| mem_rd_en | output | 1 | Digit read strobe |
| mem_rd_addr | output | ADDR_W | Digit address being read |
| mem_rd_digit | input | 4 | Read digit value, one cycle after the strobe |
| mem_rd_flag | input | 1 | Flag bit of the read digit |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Depth limit reached, valid from `done` until the next start |
| eff_bcd | output | 20 | Resolved address in BCD |
| eff_bin | output | ADDR_W | Resolved address in binary |
| levels | output | DEPTH_W | Number of indirection levels followed |
| cost | output | COST_W | Memory-time charge, 4 per level |

## Verification
The bench runs direct addresses, which must give zero reads and finish at once. It runs single hops whose fetched field has flags on its upper digits, which shows whether only the units flag is honoured. A hop from an address just above zero exposes the wrap and the read order. A self-referencing field run against limits of 0 and 3 shows that the limit stops the chain at exactly the right level. Random chains of zero to five levels, each checked against a limit drawn at random, exercise depth counting, the cost charge and latency together. A start pulse raised in the middle of a chain confirms that a busy resolver ignores it.

// File: rtl/irs_pkg.sv
// Shared definitions for the chained indirect address resolver.
// Assumes five-digit decimal addresses, 4-bit BCD per digit.
package irs_pkg;
    localparam int ADDR_DIGITS = 5;
    localparam int BCD_W       = 4 * ADDR_DIGITS;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FETCH = 2'd2,
        ST_DRAIN = 2'd3
    } irs_state_t;
endpackage

// File: rtl/irs_bcd2bin.sv
// Converts a five-digit BCD number into binary of OUT_W bits.
// Assumes every digit is 0..9 and the value fits in OUT_W bits.
module irs_bcd2bin #(
    parameter int OUT_W = 15
) (
    input  logic [irs_pkg::BCD_W-1:0] bcd,
    output logic [OUT_W-1:0]          bin
);
    // Horner evaluation from the high-order digit down
    always_comb begin
        bin = '0;
        for (int i = irs_pkg::ADDR_DIGITS - 1; i >= 0; i--) begin
            bin = OUT_W'(bin * OUT_W'(10)) + OUT_W'(bcd[4*i +: 4]);
        end
    end
endmodule

// File: rtl/irs_addr_step.sv
// Computes base minus a small offset, modulo the memory size.
// Assumes base < MEM_DIGITS and back <= 4.
module irs_addr_step #(
    parameter int MEM_DIGITS = 20000,
    parameter int ADDR_W     = $clog2(MEM_DIGITS)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [2:0]        back,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W:0] MEM_L = (ADDR_W+1)'(MEM_DIGITS);

    logic [ADDR_W:0] base_x;
    logic [ADDR_W:0] back_x;

    assign base_x = {1'b0, base};
    assign back_x = (ADDR_W+1)'(back);

    // Subtract directly, or wrap to the top of memory when below zero
    always_comb begin
        if (base_x >= back_x) begin
            addr = ADDR_W'(base_x - back_x);
        end else begin
            addr = ADDR_W'(base_x + MEM_L - back_x);
        end
    end
endmodule

// File: rtl/irs_digit_shift.sv
// Shift register of 4-bit digits; newest digit in the low bits.
// Assumes shift_en is asserted once per arriving digit.
module irs_digit_shift #(
    parameter int STAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic [3:0]            din,
    output logic [4*STAGES-1:0]   dout
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [3:0] q;
        if (g == 0) begin : g_head
            // Take the newest digit
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= '0;
                else if (shift_en) q <= din;
            end
        end else begin : g_body
            // Pass the older digit one stage up
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= '0;
                else if (shift_en) q <= g_stage[g-1].q;
            end
        end
        assign dout[4*g +: 4] = q;
    end
endmodule

// File: rtl/indirect_chain_resolver.sv
// Follows indirect address chains to an effective address.
// An address is indirect when the flag of its units digit is set.
// The next address is then the five digits stored at A-4..A, read
// one digit per cycle. The resolver stops at the first unflagged
// units digit or when the depth limit is reached.
// Assumes: one-cycle read latency, addresses below MEM_DIGITS,
// MEM_DIGITS <= 100000, and max_depth held steady while busy.
module indirect_chain_resolver #(
    parameter int MEM_DIGITS = 20000,
    parameter int DEPTH_W    = 4,
    parameter int COST_W     = 8,
    parameter int LEVEL_COST = 4,
    localparam int ADDR_W    = $clog2(MEM_DIGITS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [irs_pkg::BCD_W-1:0]  addr_bcd_in,
    input  logic                       addr_flag_in,
    input  logic [DEPTH_W-1:0]         max_depth,
    output logic                       mem_rd_en,
    output logic [ADDR_W-1:0]          mem_rd_addr,
    input  logic [3:0]                 mem_rd_digit,
    input  logic                       mem_rd_flag,
    output logic                       busy,
    output logic                       done,
    output logic                       err,
    output logic [irs_pkg::BCD_W-1:0]  eff_bcd,
    output logic [ADDR_W-1:0]          eff_bin,
    output logic [DEPTH_W-1:0]         levels,
    output logic [COST_W-1:0]          cost
);
    import irs_pkg::*;

    localparam int         UPPER   = ADDR_DIGITS - 1;
    localparam logic [2:0] LAST_IX = 3'(UPPER);

    irs_state_t            state_q;
    logic [BCD_W-1:0]      cur_bcd_q;
    logic                  cur_flag_q;
    logic [ADDR_W-1:0]     cur_bin;
    logic [ADDR_W-1:0]     base_q;
    logic [2:0]            idx_q;
    logic                  rd_valid_q;
    logic [4*UPPER-1:0]    upper_digits;
    logic [DEPTH_W-1:0]    levels_q;
    logic [COST_W-1:0]     cost_q;
    logic                  done_q;
    logic                  err_q;

    irs_bcd2bin #(.OUT_W(ADDR_W)) i_bcd2bin (
        .bcd (cur_bcd_q),
        .bin (cur_bin)
    );

    irs_addr_step #(.MEM_DIGITS(MEM_DIGITS), .ADDR_W(ADDR_W)) i_addr_step (
        .base (base_q),
        .back (LAST_IX - idx_q),
        .addr (mem_rd_addr)
    );

    irs_digit_shift #(.STAGES(UPPER)) i_digit_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rd_valid_q && (state_q == ST_FETCH)),
        .din      (mem_rd_digit),
        .dout     (upper_digits)
    );

    // Mark cycles whose read data is on the memory bus
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid_q <= 1'b0;
        else        rd_valid_q <= (state_q == ST_FETCH);
    end

    // Sequence: accept, test flag and depth, fetch five digits, replace
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cur_bcd_q  <= '0;
            cur_flag_q <= 1'b0;
            base_q     <= '0;
            idx_q      <= '0;
            levels_q   <= '0;
            cost_q     <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    done_q <= 1'b0;
                    if (start) begin
                        cur_bcd_q  <= addr_bcd_in;
                        cur_flag_q <= addr_flag_in;
                        levels_q   <= '0;
                        cost_q     <= '0;
                        err_q      <= 1'b0;
                        state_q    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!cur_flag_q) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (levels_q == max_depth) begin
                        err_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        base_q  <= cur_bin;
                        idx_q   <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    idx_q <= idx_q + 3'd1;
                    if (idx_q == LAST_IX) state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    cur_bcd_q  <= {upper_digits, mem_rd_digit};
                    cur_flag_q <= mem_rd_flag;
                    levels_q   <= levels_q + 1'b1;
                    cost_q     <= cost_q + COST_W'(LEVEL_COST);
                    state_q    <= ST_CHECK;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_en = (state_q == ST_FETCH);
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign eff_bcd   = cur_bcd_q;
    assign eff_bin   = cur_bin;
    assign levels    = levels_q;
    assign cost      = cost_q;
endmodule

// File: rtl/irs_checker.sv
// Protocol and consistency properties of the resolver, bound to it.
module irs_checker #(
    parameter int MEM_DIGITS = 20000,
    parameter int ADDR_W     = 15,
    parameter int DEPTH_W    = 4,
    parameter int COST_W     = 8,
    parameter int LEVEL_COST = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic               mem_rd_en,
    input logic [ADDR_W-1:0]  mem_rd_addr,
    input logic [DEPTH_W-1:0] max_depth,
    input logic [DEPTH_W-1:0] levels,
    input logic [COST_W-1:0]  cost
);
    AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (int'(mem_rd_addr) < MEM_DIGITS)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_en); // R2

    AST_COST_PER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(cost) == int'(levels) * LEVEL_COST)); // R6

    AST_ERR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (levels == max_depth)); // R8

    AST_LEVELS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (levels <= max_depth)); // R8

    AST_READ_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en) |=> mem_rd_en); // R3
endmodule

bind indirect_chain_resolver irs_checker #(
    .MEM_DIGITS (MEM_DIGITS),
    .ADDR_W     (ADDR_W),
    .DEPTH_W    (DEPTH_W),
    .COST_W     (COST_W),
    .LEVEL_COST (LEVEL_COST)
) i_irs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .max_depth   (max_depth),
    .levels      (levels),
    .cost        (cost)
);

// File: tb/test_indirect_chain_resolver.sv
module test_indirect_chain_resolver;
    localparam int MEM = 1000;
    localparam int DW  = 4;
    localparam int CW  = 8;
    localparam int AW  = $clog2(MEM);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [19:0]   addr_bcd_in = '0;
    logic          addr_flag_in = 1'b0;
    logic [DW-1:0] max_depth = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [3:0]    mem_rd_digit = '0;
    logic          mem_rd_flag = 1'b0;
    logic          busy, done, err;
    logic [19:0]   eff_bcd;
    logic [AW-1:0] eff_bin;
    logic [DW-1:0] levels;
    logic [CW-1:0] cost;

    int n_tests = 0;
    int n_fail  = 0;

    logic [4:0] mem [MEM];
    int rd_log [256];
    int rd_n = 0;

    always #4 clk = ~clk;

    indirect_chain_resolver #(
        .MEM_DIGITS (MEM), .DEPTH_W (DW), .COST_W (CW), .LEVEL_COST (4)
    ) i_indirect_chain_resolver (
        .clk (clk), .rst_n (rst_n), .start (start),
        .addr_bcd_in (addr_bcd_in), .addr_flag_in (addr_flag_in),
        .max_depth (max_depth), .mem_rd_en (mem_rd_en),
        .mem_rd_addr (mem_rd_addr), .mem_rd_digit (mem_rd_digit),
        .mem_rd_flag (mem_rd_flag), .busy (busy), .done (done), .err (err),
        .eff_bcd (eff_bcd), .eff_bin (eff_bin), .levels (levels), .cost (cost)
    );

    // Digit memory model with one-cycle latency and a read log
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_digit <= mem[mem_rd_addr][3:0];
            mem_rd_flag  <= mem[mem_rd_addr][4];
            rd_log[rd_n % 256] = int'(mem_rd_addr);
            rd_n = rd_n + 1;
        end
    end

    function automatic logic [19:0] to_bcd(input int v);
        return {4'(v / 10000 % 10), 4'(v / 1000 % 10), 4'(v / 100 % 10),
                4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    // Store value v as five digits ending at p; units flag uf, upper flags uflags
    task automatic put_addr(input int p, input int v, input bit uf, input bit [3:0] uflags);
        logic [19:0] b = to_bcd(v);
        for (int k = 0; k < 5; k++) begin
            int loc = (p - 4 + k + MEM) % MEM;
            mem[loc] = {(k == 4) ? uf : uflags[k], b[4*(4-k) +: 4]};
        end
    endtask

    // Reference resolution from the requirements
    task automatic model(input int a0, input bit f0, input int maxd,
                         output int ea, output int lv, output bit er);
        int a = a0;
        bit f = f0;
        lv = 0;
        er = 1'b0;
        while (f) begin
            int nv = 0;
            if (lv == maxd) begin
                er = 1'b1;
                break;
            end
            for (int k = 0; k < 5; k++) begin
                int loc = (a - 4 + k + MEM) % MEM;
                nv = nv * 10 + int'(mem[loc][3:0]);
                if (k == 4) f = mem[loc][4];
            end
            a = nv;
            lv++;
        end
        ea = a;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One resolution; poke raises a stray start in the middle when set
    task automatic run(input int a, input bit f, input int maxd, input bit poke);
        int ea, lv, n;
        bit er;
        model(a, f, maxd, ea, lv, er);
        max_depth    = DW'(maxd);
        addr_bcd_in  = to_bcd(a);
        addr_flag_in = f;
        start        = 1'b1;
        n = 0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (poke && n == 3) begin
                addr_bcd_in  = to_bcd(7);
                addr_flag_in = 1'b0;
                start        = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done || n > 400) break;
        end
        start = 1'b0;
        chk(n == 1 + 7 * lv, "R9", "done latency", n, 1 + 7 * lv);
        chk(int'(eff_bin) == ea, "R5", "effective address", int'(eff_bin), ea);
        chk(eff_bcd == to_bcd(ea), "R10", "bcd vs bin", int'(eff_bcd), int'(to_bcd(ea)));
        chk(int'(levels) == lv, "R6", "levels", int'(levels), lv);
        chk(int'(cost) == 4 * lv, "R6", "cost", int'(cost), 4 * lv);
        chk(err == er, "R8", "err", int'(err), int'(er));
        if (poke) chk(int'(eff_bin) == ea, "R11", "stray start ignored", int'(eff_bin), ea);
        @(negedge clk);
        chk(!done, "R9", "done pulse width", int'(done), 0);
    endtask

    // Random chain of L levels in separate 100-digit bins
    task automatic build_chain(input int L, output int sa);
        int p [6];
        int fin = int'($urandom % MEM);
        for (int i = 0; i < L; i++) p[i] = 100 * (i + 1) + 4 + int'($urandom % 90);
        for (int i = 0; i < L; i++) begin
            put_addr(p[i], (i + 1 < L) ? p[i + 1] : fin, (i + 1 < L), 4'($urandom));
        end
        sa = (L > 0) ? p[0] : fin;
    endtask

    initial begin
        #(8 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int base, sa, lvl, md;
        void'($urandom(32'd2024));
        for (int i = 0; i < MEM; i++) mem[i] = 5'(i % 10);

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !err && !mem_rd_en && levels == 0 && cost == 0,
            "R1", "reset outputs", int'({busy, done, err, mem_rd_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: direct address, no reads
        base = rd_n;
        run(123, 1'b0, 3, 1'b0);
        chk(rd_n == base, "R2", "reads for direct", rd_n - base, 0);

        // R3, R4: one hop, flags on upper digits ignored
        put_addr(304, 517, 1'b0, 4'b0101);
        base = rd_n;
        run(304, 1'b1, 5, 1'b0);
        for (int k = 0; k < 5; k++)
            chk(rd_log[(base + k) % 256] == 300 + k, "R3", "read order", rd_log[(base + k) % 256], 300 + k);
        chk(int'(eff_bin) == 517, "R4", "upper flags ignored", int'(eff_bin), 517);

        // R7: wrap below zero
        put_addr(2, 642, 1'b0, 4'b1111);
        base = rd_n;
        run(2, 1'b1, 5, 1'b0);
        chk(rd_log[base % 256] == 998, "R7", "first wrapped read", rd_log[base % 256], 998);
        chk(rd_log[(base + 1) % 256] == 999, "R7", "second wrapped read", rd_log[(base + 1) % 256], 999);
        chk(rd_log[(base + 2) % 256] == 0, "R7", "read at zero", rd_log[(base + 2) % 256], 0);
        chk(int'(eff_bin) == 642, "R7", "wrapped result", int'(eff_bin), 642);

        // R8: self loop stopped by limit, and limit zero
        put_addr(504, 504, 1'b1, 4'b0000);
        run(504, 1'b1, 3, 1'b0);
        chk(err && levels == 3, "R8", "loop stopped at 3", int'(levels), 3);
        base = rd_n;
        run(504, 1'b1, 0, 1'b0);
        chk(rd_n == base, "R8", "no reads at limit 0", rd_n - base, 0);

        // R5, R11: three-level chain with a stray start mid-run
        build_chain(3, sa);
        run(sa, 1'b1, 6, 1'b1);

        // R5, R6, R9: random chains against random limits
        for (int t = 0; t < 40; t++) begin
            lvl = int'($urandom % 6);
            md  = int'($urandom % 7);
            build_chain(lvl, sa);
            run(sa, lvl > 0, md, 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule